// File: doc/BRIEF.md
# NAND Controller Register Bank with Unlock Protection

This block is the software-facing register and interrupt front end of a NAND flash controller. A host reaches it over a simple word-addressed bus with read and write strobes, a 32-bit write data word and four byte enables. It holds the flash interface configuration and the flash timing settings. Both sit behind a magic-word unlock that opens the way for one write at a time. It also holds a chip-enable mode register and a command register that can reset the controller.

The controller datapath reports events as single-cycle pulses: flash ready, controller ready, ECC done (with errors-found, decode-failure and a corrected-error count), and write-protect fault. The block keeps two views of them. The raw status register shows the present state of the flash and the decoder. The interrupt status register latches each event until a read clears it. A mask selects which latched events drive the level interrupt output. A combined ready flag shows when both the flash and the controller are idle.

Register word addresses on `addr`: 0 command, 1 interface configuration, 2 timing, 3 interrupt mask, 4 interrupt status, 5 raw status, 6 lock, 7 chip-enable mode. `rdata` is combinational and valid while `rd` is high. It reads 0 when `rd` is low.

Top module: `nandc_regbank`

## Requirements
- R1: After reset every register reads 0, except the chip-enable mode register, which reads 1. The lock is closed, and `irq_o`, `dev_ready_o` and `ctrl_rst_o` are low.
- R2: A write to the configuration register (address 1) or the timing register (address 2) while the lock is closed has no effect, and the lock stays closed.
- R3: A write to address 6 with `be[1:0]`=11 and `wdata[15:0]`=0xA25E opens the lock. Any other value or byte-enable pattern does not open it. The next write to address 1 or 2 is accepted and closes the lock again, so each protected write needs its own unlock.
- R4: In the configuration register, bit 3 is write-protect enable, bit 2 is large-block device and bit 1 is five-byte addressing; all three are writable through `be[0]`. Bit 0 (16-bit bus) always reads 0.
- R5: The timing register keeps bits 25:0 and reads 0 in bits 31:26. Its fields are: bits 25:24 chip-enable-to-access delay, 23:19 busy delay, 18:16 turnaround, 15:12 read-high, 11:8 read-low, 7:4 write-high and 3:0 write-low. Each byte lane is written only when its byte enable is set.
- R6: Interrupt status bits are latched by events. Bit 5 is flash ready, bit 4 controller ready, bit 3 decode failure (ECC done together with failure), bit 2 decode error (ECC done together with errors found), bit 1 ECC ready and bit 0 write-protect fault. A read of address 4 returns the latched bits and clears them.
- R7: An event that arrives in the same cycle as a clearing read of address 4 is not returned by that read. It is held for the next read.
- R8: `irq_o` is high exactly when a latched interrupt status bit has its mask bit (same bit order, address 3, written through `be[0]`) set. Masked events are still latched.
- R9: The raw status register (address 5) has these bits: bit 6 decoder failure, bits 5:4 corrected-error count minus one, bit 3 errors found, bit 2 ECC ready, bit 1 controller ready, bit 0 flash ready. The ECC fields are loaded on each ECC-done pulse. The count reads 0 when no errors were found.
- R10: `dev_ready_o` is high only when both the controller-ready and flash-ready raw bits are set.
- R11: Writing 0xFF to the command register (address 0, `be[0]`) raises `ctrl_rst_o` for exactly one cycle, clears the raw and interrupt status, and closes the lock. Any other command value clears the raw status, which drops `dev_ready_o`.
- R12: Bit 0 of the chip-enable mode register (address 7) is writable, drives `ce_normal_o`, and needs no unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte enables |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 32 | Read data |
| ev_nand_rdy | input | 1 | Flash ready pulse |
| ev_ctrl_rdy | input | 1 | Controller ready pulse |
| ev_ecc_done | input | 1 | ECC done pulse |
| ev_err_found | input | 1 | Errors found, qualified by ECC done |
| ev_dec_fail | input | 1 | Decode failure, qualified by ECC done |
| ev_err_cnt | input | 2 | Corrected count minus one, qualified by ECC done |
| ev_wp_fault | input | 1 | Write-protect fault pulse |
| cfg_wp_o | output | 1 | Write-protect enable |
| cfg_large_o | output | 1 | Large-block device |
| cfg_long_o | output | 1 | Five-byte addressing |
| tim_o | output | 26 | Timing register contents |
| ce_normal_o | output | 1 | Controller drives chip enable |
| ctrl_rst_o | output | 1 | Controller reset pulse |
| dev_ready_o | output | 1 | Flash and controller both ready |
| irq_o | output | 1 | Level interrupt |

## Verification
Two things can land in the same cycle: a clearing read of the interrupt status and a new event from the datapath. The bench drives a flash-ready pulse in the very cycle it reads address 4. It expects that read to return only the older latched bits, and the following read to return the new bit alone. A second pairing covers a protected write followed at once by another protected write: the first is accepted and the second is refused, because the unlock is spent.

// File: rtl/nandc_rb_pkg.sv
package nandc_rb_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned IRQ_W  = 6;
  localparam int unsigned RAW_W  = 7;

  typedef enum logic [ADDR_W-1:0] {
    RA_CMD   = 3'd0,
    RA_CFG   = 3'd1,
    RA_TIM   = 3'd2,
    RA_MASK  = 3'd3,
    RA_ISTAT = 3'd4,
    RA_RAW   = 3'd5,
    RA_LOCK  = 3'd6,
    RA_CEN   = 3'd7
  } reg_addr_e;

  localparam logic [15:0] UNLOCK_WORD = 16'hA25E;
  localparam logic [7:0]  CMD_RESET   = 8'hFF;
endpackage

// File: rtl/nandc_rst_sync.sv
module nandc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/nandc_lock.sv
module nandc_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic magic_wr,
  input  logic prot_try,
  input  logic flush,
  output logic unlocked
);
  logic open_q, open_d;

  always_comb begin
    open_d = open_q;
    if (flush)         open_d = 1'b0;
    else if (prot_try) open_d = 1'b0;
    else if (magic_wr) open_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assign unlocked = open_q;
endmodule

// File: rtl/nandc_evt.sv
module nandc_evt
  import nandc_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_nand_rdy,
  input  logic             ev_ctrl_rdy,
  input  logic             ev_ecc_done,
  input  logic             ev_err_found,
  input  logic             ev_dec_fail,
  input  logic [1:0]       ev_err_cnt,
  input  logic             ev_wp_fault,
  input  logic             clr_rdy,
  input  logic             flush,
  input  logic             stat_rd,
  input  logic             mask_wr,
  input  logic [IRQ_W-1:0] mask_wdata,
  output logic [RAW_W-1:0] raw,
  output logic [IRQ_W-1:0] stat,
  output logic [IRQ_W-1:0] mask,
  output logic             irq
);
  logic [IRQ_W-1:0] stat_q, stat_d, mask_q, mask_d, ev_vec;
  logic             nrdy_q, nrdy_d, crdy_q, crdy_d;
  logic [4:0]       ecc_q, ecc_d;  // {dec_fail, cnt[1:0], err_found, ecc_rdy}

  assign ev_vec = {ev_nand_rdy, ev_ctrl_rdy, ev_ecc_done & ev_dec_fail,
                   ev_ecc_done & ev_err_found, ev_ecc_done, ev_wp_fault};

  always_comb begin
    stat_d = ((stat_rd || flush) ? '0 : stat_q) | ev_vec;
    mask_d = mask_wr ? mask_wdata : mask_q;
    nrdy_d = ev_nand_rdy ? 1'b1 : ((clr_rdy || flush) ? 1'b0 : nrdy_q);
    crdy_d = ev_ctrl_rdy ? 1'b1 : ((clr_rdy || flush) ? 1'b0 : crdy_q);
    ecc_d  = ecc_q;
    if (ev_ecc_done)
      ecc_d = {ev_dec_fail, ev_err_found ? ev_err_cnt : 2'b00, ev_err_found, 1'b1};
    else if (clr_rdy || flush)
      ecc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      nrdy_q <= 1'b0;
      crdy_q <= 1'b0;
      ecc_q  <= '0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      nrdy_q <= nrdy_d;
      crdy_q <= crdy_d;
      ecc_q  <= ecc_d;
    end
  end

  assign raw  = {ecc_q, crdy_q, nrdy_q};
  assign stat = stat_q;
  assign mask = mask_q;
  assign irq  = |(stat_q & mask_q);
endmodule

// File: rtl/nandc_regbank.sv
module nandc_regbank
  import nandc_rb_pkg::*;
#(
  parameter int unsigned TIM_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  input  logic              wr,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  input  logic              ev_nand_rdy,
  input  logic              ev_ctrl_rdy,
  input  logic              ev_ecc_done,
  input  logic              ev_err_found,
  input  logic              ev_dec_fail,
  input  logic [1:0]        ev_err_cnt,
  input  logic              ev_wp_fault,
  output logic              cfg_wp_o,
  output logic              cfg_large_o,
  output logic              cfg_long_o,
  output logic [TIM_W-1:0]  tim_o,
  output logic              ce_normal_o,
  output logic              ctrl_rst_o,
  output logic              dev_ready_o,
  output logic              irq_o
);
  localparam int unsigned TIM_BYTES = (TIM_W + 7) / 8;

  logic             rst_sync_n, unlocked;
  logic             magic_wr, prot_try, prot_wr, cmd_wr, flush, clr_rdy;
  logic             cfg_en, tim_en, cen_en, mask_wr;
  logic [2:0]       cfg_q, cfg_d;
  logic [TIM_W-1:0] tim_q, tim_d, tim_bmask;
  logic             cen_q, cen_d, crst_q;
  logic [RAW_W-1:0] raw;
  logic [IRQ_W-1:0] stat, mask;
  reg_addr_e        ra;

  nandc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign ra       = reg_addr_e'(addr);
  assign magic_wr = wr && (ra == RA_LOCK) && (be[1:0] == 2'b11) && (wdata[15:0] == UNLOCK_WORD);
  assign prot_try = wr && ((ra == RA_CFG) || (ra == RA_TIM));
  assign prot_wr  = prot_try && unlocked;
  assign cmd_wr   = wr && (ra == RA_CMD) && be[0];
  assign flush    = cmd_wr && (wdata[7:0] == CMD_RESET);
  assign clr_rdy  = cmd_wr && (wdata[7:0] != CMD_RESET);
  assign cfg_en   = prot_wr && (ra == RA_CFG) && be[0];
  assign tim_en   = prot_wr && (ra == RA_TIM);
  assign cen_en   = wr && (ra == RA_CEN) && be[0];
  assign mask_wr  = wr && (ra == RA_MASK) && be[0];

  nandc_lock u_lock (
    .clk(clk), .rst_n(rst_sync_n), .magic_wr(magic_wr),
    .prot_try(prot_try), .flush(flush), .unlocked(unlocked)
  );

  nandc_evt u_evt (
    .clk(clk), .rst_n(rst_sync_n),
    .ev_nand_rdy(ev_nand_rdy), .ev_ctrl_rdy(ev_ctrl_rdy), .ev_ecc_done(ev_ecc_done),
    .ev_err_found(ev_err_found), .ev_dec_fail(ev_dec_fail), .ev_err_cnt(ev_err_cnt),
    .ev_wp_fault(ev_wp_fault), .clr_rdy(clr_rdy), .flush(flush),
    .stat_rd(rd && (ra == RA_ISTAT)), .mask_wr(mask_wr), .mask_wdata(wdata[IRQ_W-1:0]),
    .raw(raw), .stat(stat), .mask(mask), .irq(irq_o)
  );

  for (genvar b = 0; b < TIM_BYTES; b++) begin : g_bmask
    localparam int unsigned LO = 8 * b;
    localparam int unsigned HI = (8 * b + 7 < TIM_W) ? 8 * b + 7 : TIM_W - 1;
    assign tim_bmask[HI:LO] = {(HI - LO + 1){be[b]}};
  end

  always_comb begin
    cfg_d = cfg_en ? wdata[3:1] : cfg_q;
    tim_d = tim_en ? ((tim_q & ~tim_bmask) | (wdata[TIM_W-1:0] & tim_bmask)) : tim_q;
    cen_d = cen_en ? wdata[0] : cen_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q  <= '0;
      tim_q  <= '0;
      cen_q  <= 1'b1;
      crst_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      tim_q  <= tim_d;
      cen_q  <= cen_d;
      crst_q <= flush;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (ra)
        RA_CFG:   rdata = DATA_W'({cfg_q, 1'b0});
        RA_TIM:   rdata = DATA_W'(tim_q);
        RA_MASK:  rdata = DATA_W'(mask);
        RA_ISTAT: rdata = DATA_W'(stat);
        RA_RAW:   rdata = DATA_W'(raw);
        RA_CEN:   rdata = DATA_W'(cen_q);
        default:  rdata = '0;
      endcase
    end
  end

  assign cfg_wp_o    = cfg_q[2];
  assign cfg_large_o = cfg_q[1];
  assign cfg_long_o  = cfg_q[0];
  assign tim_o       = tim_q;
  assign ce_normal_o = cen_q;
  assign ctrl_rst_o  = crst_q;
  assign dev_ready_o = raw[1] & raw[0];
endmodule

// File: rtl/nandc_regbank_chk.sv
module nandc_regbank_chk
  import nandc_rb_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr,
  input logic              rd,
  input logic [ADDR_W-1:0] addr,
  input logic              unlocked,
  input logic [2:0]        cfg_q,
  input logic              flush,
  input logic              ctrl_rst_o,
  input logic              dev_ready_o,
  input logic              irq_o,
  input logic [IRQ_W-1:0]  stat,
  input logic              ev_nand_rdy,
  input logic              ev_ctrl_rdy,
  input logic              ev_ecc_done,
  input logic              ev_wp_fault
);
  // R2
  locked_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr && addr == RA_CFG && !unlocked) |=> ($stable(cfg_q) && !unlocked));

  // R3
  relock_after_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr && (addr == RA_CFG || addr == RA_TIM) && unlocked) |=> !unlocked);

  // R7
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd && addr == RA_ISTAT && ev_nand_rdy) |=> stat[5]);

  // R8
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd && addr == RA_ISTAT && !ev_nand_rdy && !ev_ctrl_rdy && !ev_ecc_done && !ev_wp_fault)
    |=> !irq_o);

  // R10
  both_ready_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_nand_rdy && ev_ctrl_rdy) |=> dev_ready_o);

  // R11
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_rst_o |=> !ctrl_rst_o);

  // R11
  flush_locks_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |=> (!unlocked && ctrl_rst_o));
endmodule

bind nandc_regbank nandc_regbank_chk chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr(wr), .rd(rd), .addr(addr),
  .unlocked(unlocked), .cfg_q(cfg_q), .flush(flush), .ctrl_rst_o(ctrl_rst_o),
  .dev_ready_o(dev_ready_o), .irq_o(irq_o), .stat(stat),
  .ev_nand_rdy(ev_nand_rdy), .ev_ctrl_rdy(ev_ctrl_rdy),
  .ev_ecc_done(ev_ecc_done), .ev_wp_fault(ev_wp_fault)
);

// File: tb/nandc_regbank_tb_top.sv
module nandc_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] rdata;
  logic        ev_nand = 0, ev_ctrl = 0, ev_ecc = 0, ev_err = 0, ev_dfail = 0, ev_wp = 0;
  logic [1:0]  ev_cnt = '0;
  logic        cfg_wp, cfg_large, cfg_long, ce_normal, ctrl_rst, dev_ready, irq;
  logic [25:0] tim;
  int          n_checks = 0, n_errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  nandc_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .be(be), .wr(wr), .rd(rd),
    .rdata(rdata), .ev_nand_rdy(ev_nand), .ev_ctrl_rdy(ev_ctrl), .ev_ecc_done(ev_ecc),
    .ev_err_found(ev_err), .ev_dec_fail(ev_dfail), .ev_err_cnt(ev_cnt),
    .ev_wp_fault(ev_wp), .cfg_wp_o(cfg_wp), .cfg_large_o(cfg_large),
    .cfg_long_o(cfg_long), .tim_o(tim), .ce_normal_o(ce_normal), .ctrl_rst_o(ctrl_rst),
    .dev_ready_o(dev_ready), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk); addr = a; wdata = d; be = b; wr = 1'b1;
    @(negedge clk); wr = 1'b0; be = '0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic unlock();
    bus_wr(3'd6, 32'h0000A25E, 4'b0011);
  endtask

  task automatic pulse(input logic n, c, e, er, df, w, input logic [1:0] cnt);
    @(negedge clk);
    ev_nand = n; ev_ctrl = c; ev_ecc = e; ev_err = er; ev_dfail = df; ev_wp = w; ev_cnt = cnt;
    @(negedge clk);
    {ev_nand, ev_ctrl, ev_ecc, ev_err, ev_dfail, ev_wp} = '0; ev_cnt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      bus_rd(3'(a), v);
      check("R1 reset readback", v, (a == 7) ? 32'd1 : 32'd0);
    end
    check("R1 irq/ready/rst low", {29'd0, irq, dev_ready, ctrl_rst}, 32'd0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    bus_wr(3'd1, 32'hE, 4'hF);
    bus_rd(3'd1, v); check("R2 locked cfg write ignored", v, 32'h0);
    bus_wr(3'd2, 32'hFF, 4'hF);
    bus_rd(3'd2, v); check("R2 locked timing write ignored", v, 32'h0);
    unlock(); bus_wr(3'd1, 32'hF, 4'h1);
    bus_rd(3'd1, v); check("R4 cfg bit0 reads 0", v, 32'hE);
    check("R4 cfg outputs", {29'd0, cfg_wp, cfg_large, cfg_long}, 32'h7);
    bus_wr(3'd1, 32'h0, 4'h1);
    bus_rd(3'd1, v); check("R3 second write needs new unlock", v, 32'hE);
    bus_wr(3'd6, 32'h00001234, 4'b0011); bus_wr(3'd1, 32'h0, 4'h1);
    bus_rd(3'd1, v); check("R3 wrong word keeps lock", v, 32'hE);
    bus_wr(3'd6, 32'h0000A25E, 4'b0001); bus_wr(3'd1, 32'h0, 4'h1);
    bus_rd(3'd1, v); check("R3 partial byte enable keeps lock", v, 32'hE);
    unlock(); bus_wr(3'd1, 32'h4, 4'h1);
    bus_rd(3'd1, v); check("R3 unlock then write", v, 32'h4);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    unlock(); bus_wr(3'd2, 32'hFFFFFFFF, 4'hF);
    bus_rd(3'd2, v); check("R5 timing width", v, 32'h03FFFFFF);
    check("R5 timing output", {6'd0, tim}, 32'h03FFFFFF);
    unlock(); bus_wr(3'd2, 32'h0, 4'b0100);
    bus_rd(3'd2, v); check("R5 byte lane 2 only", v, 32'h0300FFFF);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    bus_wr(3'd3, 32'h3F, 4'h2);
    bus_rd(3'd3, v); check("R8 mask needs be0", v, 32'h0);
    bus_wr(3'd3, 32'h3F, 4'h1);
    pulse(0, 0, 0, 0, 0, 1, 2'b00);
    check("R8 irq high on masked event", {31'd0, irq}, 32'd1);
    bus_rd(3'd4, v); check("R6 wp fault bit0", v, 32'h01);
    check("R6 irq low after clearing read", {31'd0, irq}, 32'd0);
    bus_rd(3'd4, v); check("R6 status cleared", v, 32'h0);
    bus_wr(3'd3, 32'h0, 4'h1);
    pulse(0, 1, 0, 0, 0, 0, 2'b00);
    check("R8 masked event no irq", {31'd0, irq}, 32'd0);
    bus_rd(3'd4, v); check("R8 masked event latched", v, 32'h10);
    bus_wr(3'd3, 32'h3F, 4'h1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pulse(0, 0, 0, 0, 0, 1, 2'b00);
    @(negedge clk); addr = 3'd4; rd = 1'b1; ev_nand = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd = 1'b0; ev_nand = 1'b0;
    check("R7 colliding read returns old bits", v, 32'h01);
    check("R7 irq stays for held event", {31'd0, irq}, 32'd1);
    bus_rd(3'd4, v); check("R7 held event on next read", v, 32'h20);
  endtask

  task automatic t_raw();
    logic [31:0] v;
    bus_wr(3'd0, 32'h00, 4'h1);
    pulse(0, 0, 1, 1, 0, 0, 2'b10);
    bus_rd(3'd5, v); check("R9 raw with corrected count", v, 32'h2C);
    bus_rd(3'd4, v); check("R6 ecc ready and decode error", v, 32'h06);
    pulse(0, 0, 1, 0, 1, 0, 2'b11);
    bus_rd(3'd5, v); check("R9 raw decoder failure, no count", v, 32'h44);
    bus_rd(3'd4, v); check("R6 ecc ready and decode failure", v, 32'h0A);
    pulse(1, 0, 0, 0, 0, 0, 2'b00);
    check("R10 flash only not ready", {31'd0, dev_ready}, 32'd0);
    pulse(0, 1, 0, 0, 0, 0, 2'b00);
    check("R10 both ready", {31'd0, dev_ready}, 32'd1);
    bus_rd(3'd5, v); check("R9 ready bits", v & 32'h3, 32'h3);
  endtask

  task automatic t_cmd();
    logic [31:0] v;
    bus_rd(3'd4, v);
    bus_wr(3'd0, 32'h30, 4'h1);
    check("R11 other command drops ready", {31'd0, dev_ready}, 32'd0);
    bus_rd(3'd5, v); check("R11 other command clears raw", v, 32'h0);
    pulse(1, 0, 0, 0, 0, 1, 2'b00);
    unlock();
    @(negedge clk); addr = 3'd0; wdata = 32'hFF; be = 4'h1; wr = 1'b1;
    @(negedge clk); wr = 1'b0; be = '0;
    check("R11 reset pulse high", {31'd0, ctrl_rst}, 32'd1);
    @(negedge clk);
    check("R11 reset pulse one cycle", {31'd0, ctrl_rst}, 32'd0);
    bus_rd(3'd4, v); check("R11 interrupt status cleared", v, 32'h0);
    bus_rd(3'd5, v); check("R11 raw status cleared", v, 32'h0);
    bus_wr(3'd1, 32'h8, 4'h1);
    bus_rd(3'd1, v); check("R11 lock closed by reset command", v, 32'h4);
  endtask

  task automatic t_cen();
    logic [31:0] v;
    bus_wr(3'd7, 32'h0, 4'h1);
    bus_rd(3'd7, v); check("R12 chip-enable mode cleared", v, 32'h0);
    check("R12 ce_normal low", {31'd0, ce_normal}, 32'd0);
    bus_wr(3'd7, 32'h1, 4'h1);
    check("R12 ce_normal high", {31'd0, ce_normal}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lock();
    t_timing();
    t_irq();
    t_collide();
    t_raw();
    t_cmd();
    t_cen();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule